// File: doc/BRIEF.md
# Sample-Count Wait Accumulator

This block tells a decimating filter sequencer when enough input samples have built up to produce one output of the whole filter chain. Each incoming filter sample adds one to an internal accumulator. A ready flag is raised while the accumulator is at or above a programmed threshold. The sequencer stalls on that flag, runs every stage of the chain, and then issues a decrement command. The command subtracts one of two programmed amounts.

Normally the amount subtracted equals the total decimation of the chain. Three cascaded decimate-by-2 stages, for example, need 8 samples per output. Because the count is reduced rather than cleared, samples that arrive while the sequencer is busy are kept. Programming the second decrement value differently lets software drop inputs and shift output timing.

The accumulator is wider than the programmed fields. It clamps at zero and saturates at its maximum value. Writing the configuration word restarts the count.

Top module: `samp_wait_acc`

## Requirements
- R1: After a synchronous reset, the count is 0, all three programmed fields are 0, and `rdy` is 1.
- R2: A cycle with `smp_vld` high, and no decrement or write, raises the count by exactly one on the next clock.
- R3: `rdy` is 1 exactly when the current count is greater than or equal to the programmed threshold.
- R4: The count keeps increasing beyond the threshold, so surplus samples are retained.
- R5: With `dec_req` high, the count is reduced by decrement A when `dec_sel` is 0, and by decrement B when `dec_sel` is 1.
- R6: A sample and a decrement in the same cycle change the count by +1 minus the selected value, in one update.
- R7: A decrement larger than the count leaves the count at 0.
- R8: The count saturates at 2^AW-1 (4095 by default) and does not wrap.
- R9: A write loads the threshold from `cfg_wdata[9:0]`, decrement A from `cfg_wdata[19:10]` and decrement B from `cfg_wdata[29:20]`. The same write clears the count to 0, taking priority over a sample or decrement in that cycle.
- R10: `dec_sel` has no effect while `dec_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One filter input sample arrived this cycle |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 3*FW | Threshold, decrement A and decrement B packed together |
| dec_req | input | 1 | Decrement command from the sequencer instruction |
| dec_sel | input | 1 | Selects decrement A (0) or decrement B (1) |
| rdy | output | 1 | Enough samples are held to produce one chain output |
| avail | output | AW | Current accumulated sample count |

## Verification
On every cycle, the assertions check the following:
- the ready flag agrees with the count-versus-threshold comparison;
- a write clears the count;
- a lone sample adds one;
- a lone decrement subtracts the chosen value or floors at zero;
- a full count holds.

Only the bench's scenarios show the full behaviour over time:
- the count growing well past the threshold;
- the combined +1-minus-decrement update;
- `dec_sel` having no effect without a request;
- the bit positions of the packed configuration word;
- the long run into saturation followed by a decrement back out of it.

// File: rtl/wait_acc_pkg.sv
package wait_acc_pkg;
    localparam int FIELD_W = 10;
    localparam int ACC_W   = 12;

    typedef enum logic {
        ST_FILLING = 1'b0,
        ST_PRIMED  = 1'b1
    } wait_state_e;
endpackage

// File: rtl/wait_cfg_reg.sv
module wait_cfg_reg #(
    parameter int FW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [3*FW-1:0] wdata,
    output logic [FW-1:0] thr_q,
    output logic [FW-1:0] dec_a_q,
    output logic [FW-1:0] dec_b_q,
    output logic [FW-1:0] thr_nxt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q   <= '0;
            dec_a_q <= '0;
            dec_b_q <= '0;
        end else if (we) begin
            thr_q   <= wdata[FW-1:0];
            dec_a_q <= wdata[2*FW-1:FW];
            dec_b_q <= wdata[3*FW-1:2*FW];
        end
    end

    always_comb begin
        thr_nxt = rst ? '0 : (we ? wdata[FW-1:0] : thr_q);
    end
endmodule

// File: rtl/wait_accum.sv
module wait_accum #(
    parameter int FW = 10,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          smp,
    input  logic          dec_req,
    input  logic          dec_sel,
    input  logic [FW-1:0] dec_a,
    input  logic [FW-1:0] dec_b,
    output logic [AW-1:0] cnt_q,
    output logic [AW-1:0] cnt_nxt
);
    localparam int SW = AW + 2;
    localparam logic [AW-1:0] CNT_MAX = {AW{1'b1}};

    logic [FW-1:0] dec_val;
    logic [SW-1:0] sum;

    always_comb begin
        dec_val = dec_req ? (dec_sel ? dec_b : dec_a) : '0;
        sum = {2'b00, cnt_q} + {{(SW-1){1'b0}}, smp} - {{(SW-FW){1'b0}}, dec_val};
        if (rst || clr)
            cnt_nxt = '0;
        else if (sum[SW-1])
            cnt_nxt = '0;
        else if (sum[SW-2])
            cnt_nxt = CNT_MAX;
        else
            cnt_nxt = sum[AW-1:0];
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_nxt;
    end

    // R2: a lone sample adds one below the ceiling
    a_r2_sample_inc: assert property (@(posedge clk) disable iff (rst)
        (smp && !dec_req && !clr && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R5: a lone decrement subtracts the chosen value
    a_r5_dec_sub: assert property (@(posedge clk) disable iff (rst)
        (dec_req && !smp && !clr && cnt_q >= AW'(dec_sel ? dec_b : dec_a))
        |=> cnt_q == $past(cnt_q) - AW'($past(dec_sel) ? $past(dec_b) : $past(dec_a)));

    // R7: an oversized decrement floors at zero
    a_r7_floor: assert property (@(posedge clk) disable iff (rst)
        (dec_req && !smp && !clr && cnt_q < AW'(dec_sel ? dec_b : dec_a)) |=> cnt_q == '0);

    // R8: a full count stays full on a sample
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (smp && !dec_req && !clr && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R9: a write clears the count
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/wait_flag_fsm.sv
module wait_flag_fsm
    import wait_acc_pkg::*;
#(
    parameter int FW = 10,
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cnt_nxt,
    input  logic [FW-1:0] thr_nxt,
    output logic          rdy
);
    wait_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_FILLING: state_d = (cnt_nxt >= AW'(thr_nxt)) ? ST_PRIMED : ST_FILLING;
            ST_PRIMED:  state_d = (cnt_nxt <  AW'(thr_nxt)) ? ST_FILLING : ST_PRIMED;
            default:    state_d = ST_FILLING;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_PRIMED;
        else
            state_q <= state_d;
    end

    always_comb begin
        rdy = (state_q == ST_PRIMED);
    end
endmodule

// File: rtl/samp_wait_acc.sv
module samp_wait_acc
    import wait_acc_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int AW = ACC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_vld,
    input  logic            cfg_we,
    input  logic [3*FW-1:0] cfg_wdata,
    input  logic            dec_req,
    input  logic            dec_sel,
    output logic            rdy,
    output logic [AW-1:0]   avail
);
    logic [FW-1:0] thr_q, dec_a_q, dec_b_q, thr_nxt;
    logic [AW-1:0] cnt_nxt;

    wait_cfg_reg #(.FW(FW)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
        .thr_q(thr_q), .dec_a_q(dec_a_q), .dec_b_q(dec_b_q), .thr_nxt(thr_nxt)
    );

    wait_accum #(.FW(FW), .AW(AW)) u_acc (
        .clk(clk), .rst(rst), .clr(cfg_we), .smp(smp_vld),
        .dec_req(dec_req), .dec_sel(dec_sel), .dec_a(dec_a_q), .dec_b(dec_b_q),
        .cnt_q(avail), .cnt_nxt(cnt_nxt)
    );

    wait_flag_fsm #(.FW(FW), .AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .cnt_nxt(cnt_nxt), .thr_nxt(thr_nxt), .rdy(rdy)
    );

    // R3: the flag tracks count against threshold
    a_r3_flag_match: assert property (@(posedge clk) disable iff (rst)
        rdy == (avail >= AW'(thr_q)));
endmodule

// File: tb/sim_samp_wait_acc.sv
`timescale 1ns/1ps
module sim_samp_wait_acc;
    localparam int FW = 10;
    localparam int AW = 12;
    localparam int MAXC = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld = 1'b0, cfg_we = 1'b0, dec_req = 1'b0, dec_sel = 1'b0;
    logic [3*FW-1:0] cfg_wdata = '0;
    logic rdy;
    logic [AW-1:0] avail;

    int n_chk = 0;
    int n_fail = 0;
    int m_cnt = 0, m_thr = 0, m_a = 0, m_b = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    samp_wait_acc #(.FW(FW), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .dec_req(dec_req), .dec_sel(dec_sel),
        .rdy(rdy), .avail(avail)
    );

    task automatic check(string tag);
        n_chk++;
        if (int'(avail) != m_cnt) begin
            n_fail++;
            $display("FAIL %s count actual=%0d expected=%0d", tag, avail, m_cnt);
        end
        n_chk++;
        if (rdy != (m_cnt >= m_thr)) begin
            n_fail++;
            $display("FAIL %s rdy actual=%0b expected=%0b", tag, rdy, m_cnt >= m_thr);
        end
    endtask

    task automatic step(input bit s, input bit r, input bit sel, input bit w,
                        input int thr, input int da, input int db, input string tag);
        int nxt;
        smp_vld = s; dec_req = r; dec_sel = sel; cfg_we = w;
        cfg_wdata = {db[FW-1:0], da[FW-1:0], thr[FW-1:0]};
        if (w) begin
            nxt = 0; m_thr = thr; m_a = da; m_b = db;
        end else begin
            nxt = m_cnt + (s ? 1 : 0) - (r ? (sel ? m_b : m_a) : 0);
            if (nxt < 0) nxt = 0;
            if (nxt > MAXC) nxt = MAXC;
        end
        @(posedge clk);
        m_cnt = nxt;
        @(negedge clk);
        smp_vld = 0; dec_req = 0; cfg_we = 0; dec_sel = 0;
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1");
        // R9: program thr=8, A=8, B=5
        step(0,0,0,1, 8,8,5, "R9");
        for (int i = 0; i < 7; i++) step(1,0,0,0, 0,0,0, "R2");
        step(1,0,0,0, 0,0,0, "R3");
        for (int i = 0; i < 3; i++) step(1,0,0,0, 0,0,0, "R4");
        step(0,1,0,0, 0,0,0, "R5");
        // R10: select toggled without a request
        step(1,0,1,0, 0,0,0, "R10");
        step(0,0,1,0, 0,0,0, "R10");
        for (int i = 0; i < 6; i++) step(1,0,0,0, 0,0,0, "R2");
        step(0,1,1,0, 0,0,0, "R5");
        step(1,1,0,0, 0,0,0, "R6");
        step(1,1,1,0, 0,0,0, "R6");
        step(0,1,0,0, 0,0,0, "R7");
        for (int i = 0; i < 4; i++) step(1,0,0,0, 0,0,0, "R2");
        step(0,0,0,1, 3,2,9, "R9");
        for (int i = 0; i < 4; i++) step(1,0,0,0, 0,0,0, "R3");
        step(0,1,1,0, 0,0,0, "R7");
        step(0,0,0,1, 1023,8,1, "R9");
        for (int i = 0; i < MAXC + 6; i++) step(1,0,0,0, 0,0,0, "R8");
        step(0,1,0,0, 0,0,0, "R8");
        step(1,0,0,1, 2,4,6, "R9");
        step(1,1,1,0, 0,0,0, "R7");
        rst = 1'b1;
        @(posedge clk);
        m_cnt = 0; m_thr = 0; m_a = 0; m_b = 0;
        @(negedge clk);
        rst = 1'b0;
        check("R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule